// File: doc/BRIEF.md
# Indexed Event Counter Bank

The block keeps a small set of wide event counters for performance monitoring. Each counter is tied to one hardware condition, picked from a vector of one-cycle condition pulses, by a configuration register of its own. Software does not see the counters directly. It writes a counter number into a selector register, and a shared group of register addresses then acts on that counter. Those addresses cover the configuration, the live count and a two-word snapshot.

Counting is started and stopped for the whole bank by one enable bit. A single counter is halted by tying it to condition 0, which never fires. To read a running counter without tearing, software sets the capture bit. The whole counter is then copied into the snapshot registers in one cycle, and software reads the two 32-bit halves at leisure.

A read-only description register reports the bank geometry. A second selector register walks a table of condition descriptors, and each descriptor returns an 8-character ASCII label.

Top module: `evt_ctr_bank`

## Requirements
- R1: The register address map is as follows. 0 is the counter selector, 1 is control, 2 is the selected counter's condition, 3 and 4 are the selected count bits 31:0 and the bits above 31, 5 and 6 are the snapshot bits 31:0 and the bits above 31, 7 is the bank description, 8 is the condition selector, 9 and 10 are label bytes 0-3 and 4-7, and 11 is the condition description. Addresses 2 to 4 act on the counter given by the last value written to the counter selector, and both selectors read back their value.
- R2: A counter adds one on each clock in which control bit 0 is set, its condition number is not 0, and `events[condition]` is high.
- R3: A counter whose condition number is 0 never changes through counting, whatever the event inputs do.
- R4: Control bit 0 gates counting for all counters at once. Control bits 31:2 and bit 0 read back as written. Bit 1 always reads 0.
- R5: Writing control with bit 1 set copies the selected counter into the snapshot in one step. If an increment lands in the same cycle, the value captured is the one before that increment. The snapshot then holds still while the counter keeps running.
- R6: Writes to addresses 3 and 4 load the selected counter's low and high bits. A load takes priority over an increment in the same cycle. High bits beyond the counter width are dropped, and reads of high words are zero-extended.
- R7: A counter is `32+16*SIZE_SEL` bits wide. It carries from bit 31 into bit 32, and it wraps to zero modulo 2^width.
- R8: The bank description reads bits 7:0 as the number of counters and bits 15:8 as SIZE_SEL. All other bits read 0.
- R9: The condition description reads bits 7:0 as the number of conditions and bit 31 as 1. Condition 0's label is "NEVER" followed by three spaces. Condition k>0 is labelled 'E','V','T','_', then the tens digit and the units digit of k, then two spaces. Byte 0 sits in bits 7:0 of address 9.
- R10: A synchronous reset clears every count, every condition number (to 0), the control register, the snapshot and both selectors.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data (combinational on addr) |
| events | input | NUM_CONDS | One-cycle condition pulses, bit k is condition k |

## Verification
The assertions assume that one register access at most is presented per cycle. They also assume that no write occurs in a cycle whose counting they check, because a write may move the selector or load the count. The stimulus respects this: it holds the event vector at zero during configuration writes, except in the deliberate same-cycle cases for capture and load priority. The checks of increments and halts are made only on cycles without a write strobe.

// File: rtl/evt_pkg.sv
package evt_pkg;

   typedef enum logic [3:0] {
      A_CTR_SEL    = 4'd0,
      A_CTRL       = 4'd1,
      A_CFG        = 4'd2,
      A_CNT_LO     = 4'd3,
      A_CNT_HI     = 4'd4,
      A_SNAP_LO    = 4'd5,
      A_SNAP_HI    = 4'd6,
      A_BUILD      = 4'd7,
      A_COND_SEL   = 4'd8,
      A_NAME_LO    = 4'd9,
      A_NAME_HI    = 4'd10,
      A_COND_BUILD = 4'd11
   } reg_addr_e;

   localparam int CTRL_RUN_BIT  = 0;
   localparam int CTRL_SNAP_BIT = 1;

   // Eight-byte label, byte 0 in bits 7:0
   function automatic logic [63:0] cond_label(input int unsigned k);
      logic [63:0] n;
      if (k == 0) begin
         n[7:0]   = 8'h4E;
         n[15:8]  = 8'h45;
         n[23:16] = 8'h56;
         n[31:24] = 8'h45;
         n[39:32] = 8'h52;
         n[47:40] = 8'h20;
         n[55:48] = 8'h20;
         n[63:56] = 8'h20;
      end else begin
         n[7:0]   = 8'h45;
         n[15:8]  = 8'h56;
         n[23:16] = 8'h54;
         n[31:24] = 8'h5F;
         n[39:32] = 8'h30 + 8'(k / 10);
         n[47:40] = 8'h30 + 8'(k % 10);
         n[55:48] = 8'h20;
         n[63:56] = 8'h20;
      end
      return n;
   endfunction

endpackage

// File: rtl/evt_ctr_cell.sv
module evt_ctr_cell #(
   parameter int CNT_W = 48,
   parameter int NC    = 8,
   parameter int CW    = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             run,
   input  logic [NC-1:0]    events,
   input  logic             sel,
   input  logic             wr_cfg,
   input  logic             wr_lo,
   input  logic             wr_hi,
   input  logic [31:0]      wdata,
   output logic [CW-1:0]    cfg_q,
   output logic [CNT_W-1:0] cnt_q
);

   logic             hit;
   logic             load;
   logic [CNT_W-1:0] cnt_ld;

   assign hit  = run && (cfg_q != '0) && events[cfg_q];
   assign load = sel && (wr_lo || wr_hi);

   generate
      if (CNT_W == 32) begin : g_narrow
         always_comb begin
            cnt_ld = cnt_q;
            if (wr_lo) cnt_ld = wdata;
         end
      end else begin : g_wide
         always_comb begin
            cnt_ld = cnt_q;
            if (wr_lo) cnt_ld[31:0]      = wdata;
            if (wr_hi) cnt_ld[CNT_W-1:32] = wdata[CNT_W-33:0];
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         cfg_q <= '0;
         cnt_q <= '0;
      end else begin
         if (sel && wr_cfg) cfg_q <= wdata[CW-1:0];
         if (load)          cnt_q <= cnt_ld;
         else if (hit)      cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/evt_snap_reg.sv
module evt_snap_reg #(
   parameter int CNT_W = 48
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             capture,
   input  logic [CNT_W-1:0] value,
   output logic [CNT_W-1:0] snap_q,
   output logic [31:0]      snap_lo,
   output logic [31:0]      snap_hi
);

   logic [63:0] snap_ext;

   always_ff @(posedge clk) begin
      if (rst)          snap_q <= '0;
      else if (capture) snap_q <= value;
   end

   assign snap_ext = 64'(snap_q);
   assign snap_lo  = snap_ext[31:0];
   assign snap_hi  = snap_ext[63:32];

endmodule

// File: rtl/evt_ident.sv
module evt_ident
   import evt_pkg::*;
#(
   parameter int NUM_CTRS  = 4,
   parameter int SIZE_SEL  = 1,
   parameter int NUM_CONDS = 8,
   parameter int CW        = 3
) (
   input  logic [CW-1:0] cond_sel,
   output logic [31:0]   bank_desc,
   output logic [31:0]   cond_desc,
   output logic [31:0]   label_lo,
   output logic [31:0]   label_hi
);

   logic [63:0] label;

   assign bank_desc = {16'h0, 8'(SIZE_SEL), 8'(NUM_CTRS)};
   assign cond_desc = {1'b1, 23'h0, 8'(NUM_CONDS)};
   assign label     = cond_label(int'(cond_sel));
   assign label_lo  = label[31:0];
   assign label_hi  = label[63:32];

endmodule

// File: rtl/evt_ctr_bank.sv
module evt_ctr_bank
   import evt_pkg::*;
#(
   parameter int NUM_CTRS  = 4,
   parameter int SIZE_SEL  = 1,
   parameter int NUM_CONDS = 8
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 wr_en,
   input  logic [3:0]           addr,
   input  logic [31:0]          wdata,
   output logic [31:0]          rdata,
   input  logic [NUM_CONDS-1:0] events
);

   localparam int CNT_W = 32 + 16 * SIZE_SEL;
   localparam int IW    = (NUM_CTRS > 1) ? $clog2(NUM_CTRS) : 1;
   localparam int CW    = $clog2(NUM_CONDS);

   generate
      if (NUM_CTRS < 1 || NUM_CTRS > 64 || (NUM_CTRS & (NUM_CTRS - 1)) != 0) begin : g_bad_ctrs
         $error("NUM_CTRS must be a power of two from 1 to 64");
      end
      if (NUM_CONDS < 2 || NUM_CONDS > 64 || (NUM_CONDS & (NUM_CONDS - 1)) != 0) begin : g_bad_conds
         $error("NUM_CONDS must be a power of two from 2 to 64");
      end
      if (SIZE_SEL < 0 || SIZE_SEL > 2) begin : g_bad_size
         $error("SIZE_SEL must be 0, 1 or 2");
      end
   endgenerate

   logic [IW-1:0]    ctr_sel_q;
   logic [CW-1:0]    cond_sel_q;
   logic [31:0]      ctrl_q;
   logic             wr_ctr_sel, wr_ctrl, wr_cfg, wr_lo, wr_hi, wr_cond_sel;
   logic             snap_req;
   logic             run;
   logic [CW-1:0]    cfg_arr [NUM_CTRS];
   logic [CNT_W-1:0] cnt_arr [NUM_CTRS];
   logic [CW-1:0]    cur_cfg;
   logic [CNT_W-1:0] cur_cnt;
   logic [63:0]      cur_ext;
   logic [CNT_W-1:0] snap_val;
   logic [31:0]      snap_lo, snap_hi;
   logic [31:0]      bank_desc, cond_desc, label_lo, label_hi;

   assign wr_ctr_sel  = wr_en && (addr == A_CTR_SEL);
   assign wr_ctrl     = wr_en && (addr == A_CTRL);
   assign wr_cfg      = wr_en && (addr == A_CFG);
   assign wr_lo       = wr_en && (addr == A_CNT_LO);
   assign wr_hi       = wr_en && (addr == A_CNT_HI);
   assign wr_cond_sel = wr_en && (addr == A_COND_SEL);
   assign snap_req    = wr_ctrl && wdata[CTRL_SNAP_BIT];
   assign run         = ctrl_q[CTRL_RUN_BIT];

   always_ff @(posedge clk) begin
      if (rst) begin
         ctr_sel_q  <= '0;
         cond_sel_q <= '0;
         ctrl_q     <= '0;
      end else begin
         if (wr_ctr_sel)  ctr_sel_q  <= wdata[IW-1:0];
         if (wr_cond_sel) cond_sel_q <= wdata[CW-1:0];
         if (wr_ctrl)     ctrl_q     <= wdata & ~(32'h1 << CTRL_SNAP_BIT);
      end
   end

   generate
      for (genvar i = 0; i < NUM_CTRS; i++) begin : g_ctr
         evt_ctr_cell #(
            .CNT_W (CNT_W),
            .NC    (NUM_CONDS),
            .CW    (CW)
         ) u_cell (
            .clk    (clk),
            .rst    (rst),
            .run    (run),
            .events (events),
            .sel    (ctr_sel_q == IW'(i)),
            .wr_cfg (wr_cfg),
            .wr_lo  (wr_lo),
            .wr_hi  (wr_hi),
            .wdata  (wdata),
            .cfg_q  (cfg_arr[i]),
            .cnt_q  (cnt_arr[i])
         );
      end
   endgenerate

   assign cur_cfg = cfg_arr[ctr_sel_q];
   assign cur_cnt = cnt_arr[ctr_sel_q];
   assign cur_ext = 64'(cur_cnt);

   evt_snap_reg #(.CNT_W(CNT_W)) u_snap (
      .clk     (clk),
      .rst     (rst),
      .capture (snap_req),
      .value   (cur_cnt),
      .snap_q  (snap_val),
      .snap_lo (snap_lo),
      .snap_hi (snap_hi)
   );

   evt_ident #(
      .NUM_CTRS  (NUM_CTRS),
      .SIZE_SEL  (SIZE_SEL),
      .NUM_CONDS (NUM_CONDS),
      .CW        (CW)
   ) u_ident (
      .cond_sel  (cond_sel_q),
      .bank_desc (bank_desc),
      .cond_desc (cond_desc),
      .label_lo  (label_lo),
      .label_hi  (label_hi)
   );

   always_comb begin
      case (addr)
         A_CTR_SEL:    rdata = 32'(ctr_sel_q);
         A_CTRL:       rdata = ctrl_q;
         A_CFG:        rdata = 32'(cur_cfg);
         A_CNT_LO:     rdata = cur_ext[31:0];
         A_CNT_HI:     rdata = cur_ext[63:32];
         A_SNAP_LO:    rdata = snap_lo;
         A_SNAP_HI:    rdata = snap_hi;
         A_BUILD:      rdata = bank_desc;
         A_COND_SEL:   rdata = 32'(cond_sel_q);
         A_NAME_LO:    rdata = label_lo;
         A_NAME_HI:    rdata = label_hi;
         A_COND_BUILD: rdata = cond_desc;
         default:      rdata = '0;
      endcase
   end

endmodule

// File: rtl/evt_ctr_bank_chk.sv
module evt_ctr_bank_chk
   import evt_pkg::*;
#(
   parameter int CNT_W = 48,
   parameter int IW    = 2,
   parameter int CW    = 3,
   parameter int NC    = 8
) (
   input logic             clk,
   input logic             rst,
   input logic             wr_en,
   input logic [3:0]       addr,
   input logic [31:0]      wdata,
   input logic [NC-1:0]    events,
   input logic [31:0]      ctrl_q,
   input logic [IW-1:0]    ctr_sel_q,
   input logic [CW-1:0]    cur_cfg,
   input logic [CNT_W-1:0] cur_cnt,
   input logic [CNT_W-1:0] snap_val
);

   a_r10_reset_clear: assert property (@(posedge clk)
      rst |=> (ctrl_q == '0 && ctr_sel_q == '0 && cur_cnt == '0 && cur_cfg == '0 && snap_val == '0));

   a_r1_select: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr == A_CTR_SEL) |=> ctr_sel_q == $past(wdata[IW-1:0]));

   a_r2_count_up: assert property (@(posedge clk) disable iff (rst)
      (!wr_en && ctrl_q[CTRL_RUN_BIT] && cur_cfg != '0 && events[cur_cfg])
      |=> cur_cnt == CNT_W'($past(cur_cnt) + 1'b1));

   a_r3_never_moves: assert property (@(posedge clk) disable iff (rst)
      (!wr_en && cur_cfg == '0) |=> $stable(cur_cnt));

   a_r4_bank_off: assert property (@(posedge clk) disable iff (rst)
      (!wr_en && !ctrl_q[CTRL_RUN_BIT]) |=> $stable(cur_cnt));

   a_r4_snap_bit_clear: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr == A_CTRL) |=> !ctrl_q[CTRL_SNAP_BIT]);

   a_r5_capture: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr == A_CTRL && wdata[CTRL_SNAP_BIT]) |=> snap_val == $past(cur_cnt));

   a_r5_snap_hold: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && addr == A_CTRL && wdata[CTRL_SNAP_BIT]) |=> $stable(snap_val));

endmodule

bind evt_ctr_bank evt_ctr_bank_chk #(
   .CNT_W (CNT_W),
   .IW    (IW),
   .CW    (CW),
   .NC    (NUM_CONDS)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .wr_en     (wr_en),
   .addr      (addr),
   .wdata     (wdata),
   .events    (events),
   .ctrl_q    (ctrl_q),
   .ctr_sel_q (ctr_sel_q),
   .cur_cfg   (cur_cfg),
   .cur_cnt   (cur_cnt),
   .snap_val  (snap_val)
);

// File: tb/evt_ctr_bank_tb.sv
`timescale 1ns/1ps
module evt_ctr_bank_tb;
   import evt_pkg::*;

   localparam int NC = 4;
   localparam int SS = 1;
   localparam int NK = 8;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          wr_en = 1'b0;
   logic [3:0]    addr = '0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic [NK-1:0] events = '0;

   int checks = 0;
   int errors = 0;
   longint exp_cnt [NC];

   always #2 clk = ~clk;

   evt_ctr_bank #(.NUM_CTRS(NC), .SIZE_SEL(SS), .NUM_CONDS(NK)) u_dut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .events(events)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // all tasks start and end just after a falling edge
   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      addr = a;
      #0.5;
      d = rdata;
      @(negedge clk);
   endtask

   task automatic rdcnt(output logic [63:0] v);
      logic [31:0] lo, hi;
      rd(A_CNT_LO, lo);
      rd(A_CNT_HI, hi);
      v = {hi, lo};
   endtask

   task automatic pulse(input logic [NK-1:0] ev);
      events = ev;
      @(negedge clk);
      events = '0;
   endtask

   function automatic logic [63:0] exp_label(input int k);
      byte s [8];
      logic [63:0] n;
      if (k == 0) s = '{"N", "E", "V", "E", "R", " ", " ", " "};
      else        s = '{"E", "V", "T", "_", byte'(48 + k / 10), byte'(48 + k % 10), " ", " "};
      for (int b = 0; b < 8; b++) n[b*8 +: 8] = s[b];
      return n;
   endfunction

   initial begin
      #(200000 * 4);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] r;
      logic [63:0] v;
      repeat (3) @(negedge clk);
      rst = 1'b0;

      // R10 reset state
      rd(A_CTRL, r);      chk("R10 ctrl", 64'(r), 64'h0);
      rd(A_CTR_SEL, r);   chk("R10 ctr sel", 64'(r), 64'h0);
      rd(A_COND_SEL, r);  chk("R10 cond sel", 64'(r), 64'h0);
      rd(A_SNAP_LO, r);   chk("R10 snap", 64'(r), 64'h0);
      for (int i = 0; i < NC; i++) begin
         wr(A_CTR_SEL, 32'(i));
         rd(A_CFG, r);  chk("R10 cfg", 64'(r), 64'h0);
         rdcnt(v);      chk("R10 count", v, 64'h0);
      end

      // R8 / R9 description registers and labels
      rd(A_BUILD, r);      chk("R8 bank desc", 64'(r), 64'h0000_0104);
      rd(A_COND_BUILD, r); chk("R9 cond desc", 64'(r), 64'h8000_0008);
      for (int k = 0; k < NK; k++) begin
         logic [31:0] lo, hi;
         wr(A_COND_SEL, 32'(k));
         rd(A_NAME_LO, lo);
         rd(A_NAME_HI, hi);
         chk("R9 label", {hi, lo}, exp_label(k));
      end

      // R1 R2 R3 sweep of every counter over every condition
      wr(A_CTRL, 32'h1);
      for (int i = 0; i < NC; i++) begin
         wr(A_CTR_SEL, 32'(i));
         rd(A_CTR_SEL, r); chk("R1 sel readback", 64'(r), 64'(i));
         for (int k = 1; k < NK; k++) begin
            int e;
            logic [7:0] ev;
            e = 0;
            wr(A_CNT_LO, 32'h0);
            wr(A_CNT_HI, 32'h0);
            wr(A_CFG, 32'(k));
            rd(A_CFG, r); chk("R1 cfg readback", 64'(r), 64'(k));
            for (int t = 0; t < 30; t++) begin
               ev = 8'(t * 37 + i * 11 + k * 5);
               if (ev[k]) e++;
               pulse(ev);
            end
            wr(A_CFG, 32'h0);
            rdcnt(v); chk("R2 count", v, 64'(e));
            pulse(8'hFF);
            pulse(8'hFF);
            rdcnt(v); chk("R3 never", v, 64'(e));
            exp_cnt[i] = longint'(e);
         end
      end
      for (int i = 0; i < NC; i++) begin
         wr(A_CTR_SEL, 32'(i));
         rdcnt(v); chk("R1 isolation", v, 64'(exp_cnt[i]));
      end

      // R4 global enable and control bit behaviour
      wr(A_CTR_SEL, 32'h0);
      wr(A_CNT_LO, 32'h0);
      wr(A_CNT_HI, 32'h0);
      wr(A_CFG, 32'h3);
      wr(A_CTRL, 32'hABCD_0000);
      repeat (5) pulse(8'hFF);
      rdcnt(v);       chk("R4 stopped", v, 64'h0);
      rd(A_CTRL, r);  chk("R4 ctrl readback", 64'(r), 64'hABCD_0000);
      wr(A_CTRL, 32'hABCD_0003);
      rd(A_CTRL, r);  chk("R4 snap bit clear", 64'(r), 64'hABCD_0001);
      repeat (3) pulse(8'hFF);
      rdcnt(v);       chk("R4 running", v, 64'h3);

      // R7 wrap and carry
      wr(A_CNT_LO, 32'hFFFF_FFFF);
      wr(A_CNT_HI, 32'h0000_FFFF);
      pulse(8'h08);
      rdcnt(v); chk("R7 wrap", v, 64'h0);
      wr(A_CNT_LO, 32'hFFFF_FFFF);
      wr(A_CNT_HI, 32'h0);
      pulse(8'h08);
      rdcnt(v); chk("R7 carry", v, 64'h1_0000_0000);

      // R6 high bits beyond width and load priority
      wr(A_CNT_HI, 32'hFFFF_1234);
      rd(A_CNT_HI, r); chk("R6 hi truncate", 64'(r), 64'h1234);
      wr_en = 1'b1; addr = A_CNT_LO; wdata = 32'd55; events = 8'h08;
      @(negedge clk);
      wr_en = 1'b0; events = '0;
      rd(A_CNT_LO, r); chk("R6 load wins", 64'(r), 64'd55);

      // R5 capture with coincident increment, then hold
      wr(A_CNT_LO, 32'd100);
      wr(A_CNT_HI, 32'd7);
      wr_en = 1'b1; addr = A_CTRL; wdata = 32'h3; events = 8'h08;
      @(negedge clk);
      wr_en = 1'b0; events = '0;
      rd(A_SNAP_LO, r); chk("R5 snap lo pre-inc", 64'(r), 64'd100);
      rd(A_SNAP_HI, r); chk("R5 snap hi", 64'(r), 64'd7);
      rdcnt(v);         chk("R5 live count", v, 64'h7_0000_0065);
      repeat (4) pulse(8'h08);
      rd(A_SNAP_LO, r); chk("R5 snap hold", 64'(r), 64'd100);
      rdcnt(v);         chk("R5 live after", v, 64'h7_0000_0069);

      // R10 reset in mid run
      wr(A_CTR_SEL, 32'h2);
      wr(A_COND_SEL, 32'h5);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      rd(A_CTRL, r);     chk("R10 ctrl after", 64'(r), 64'h0);
      rd(A_CTR_SEL, r);  chk("R10 sel after", 64'(r), 64'h0);
      rd(A_COND_SEL, r); chk("R10 cond sel after", 64'(r), 64'h0);
      rd(A_SNAP_HI, r);  chk("R10 snap after", 64'(r), 64'h0);
      for (int i = 0; i < NC; i++) begin
         wr(A_CTR_SEL, 32'(i));
         rd(A_CFG, r); chk("R10 cfg after", 64'(r), 64'h0);
         rdcnt(v);     chk("R10 count after", v, 64'h0);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule